// File: doc/BRIEF.md
# Morse Code Letter Encoder

This block sends the Morse code of one letter from S to Z on a single LED output. A 3-bit select input picks the letter. A rising edge on the start input copies a fixed 16-bit pattern for that letter into a shift register. The register then moves one bit to the LED for every half-second slot.

The pattern is stored in time slices. Each slice lasts one slot. A dot is one high slice, a dash is three high slices, and one low slice separates elements. Every pattern is padded with low slices to the full length. After the last slice the block goes idle and holds the LED low. It sends again only on the next start edge.

The slot length comes from an internal divider on the system clock. The clock frequency is a parameter, so a bench can use very short slots. An active-low reset clears the block at once, whatever the clock is doing.

Top module: `morse_letter_tx`

## Requirements
- R1: The letter select codes are 000=S, 001=T, 010=U, 011=V, 100=W, 101=X, 110=Y and 111=Z. The 16-slot patterns, written first slot first, are:
  - S: 1010100000000000
  - T: 1110000000000000
  - U: 1010111000000000
  - V: 1010101110000000
  - W: 1011101110000000
  - X: 1110101011100000
  - Y: 1110101110111000
  - Z: 1110111010100000
- R2: Each pattern bit is driven for exactly CLK_HZ/SLOTS_PER_SEC clock cycles. With the defaults this is 0.5 s. The first bit also gets its full duration, because the slot divider restarts when the pattern is loaded.
- R3: The pattern is sent most significant bit first. `led_o` shows the first bit starting on the clock edge that samples the start rising edge.
- R4: After the 16th slot, `led_o` stays low and the letter is not repeated.
- R5: Playback starts only on a low-to-high change of `start_i`. Holding `start_i` high does not start a second playback.
- R6: A start edge that arrives during playback is ignored. The pattern that is playing continues unchanged.
- R7: `letter_i` is sampled only when a playback is loaded. Changing it during playback does not alter the output.
- R8: Driving `rst_ni` low forces `led_o` low at once, without waiting for a clock edge. The block then stays idle until the next start edge.
- R9: Out of reset, `led_o` is low.
- R10: A new start edge after a playback has finished, or after a reset, plays the newly selected letter in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; its rising edge is used |
| letter_i | input | 3 | Letter select, 000=S through 111=Z |
| led_o | output | 1 | Morse output, high while a pattern bit is 1 |

## Verification
All eight letter codes are played in turn. Because the slot sequence is compared cycle by cycle, any error in a letter's pattern, in the bit order, or in the slot length shows up as a mismatch. Other playbacks add disturbances: start held high through the whole run, a second start edge with a different letter in the middle, and the select lines changing while a letter plays. Each of these must leave the output identical to a clean playback, which separates edge detection and load gating from level-sensitive behaviour. A reset in the middle of a letter, checked before the next clock edge and then through a quiet period, tells an asynchronous clear apart from a synchronous one. It also shows whether any leftover state survives the reset.

// File: rtl/morse_pkg.sv
package morse_pkg;

    // Number of time slices held for every letter
    localparam int unsigned PAT_W = 16;

    typedef enum logic [2:0] {
        LTR_S = 3'd0,
        LTR_T = 3'd1,
        LTR_U = 3'd2,
        LTR_V = 3'd3,
        LTR_W = 3'd4,
        LTR_X = 3'd5,
        LTR_Y = 3'd6,
        LTR_Z = 3'd7
    } letter_e;

    typedef logic [PAT_W-1:0] pattern_t;

endpackage

// File: rtl/morse_slot_timer.sv
module morse_slot_timer #(
    parameter int unsigned CYCLES_PER_SLOT = 25_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);

    localparam int unsigned CW = (CYCLES_PER_SLOT > 1) ? $clog2(CYCLES_PER_SLOT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_SLOT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    // Count down from LAST; the slot ends when zero is reached
    always_comb begin
        cnt_d = cnt_q;
        if (restart_i || !run_i) begin
            cnt_d = LAST;
        end else if (cnt_q == '0) begin
            cnt_d = LAST;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= LAST;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && !restart_i && (cnt_q == '0);

    // R2
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

    generate
        if (CYCLES_PER_SLOT > 1) begin : g_gap
            // R2
            tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/morse_pattern_rom.sv
module morse_pattern_rom
    import morse_pkg::*;
(
    input  logic [2:0] letter_i,
    output pattern_t   pattern_o
);

    // 1 = LED on for one slot; a dot is 1, a dash is 111, and a 0 follows each element
    always_comb begin
        unique case (letter_e'(letter_i))
            LTR_S:   pattern_o = 16'hA800;
            LTR_T:   pattern_o = 16'hE000;
            LTR_U:   pattern_o = 16'hAE00;
            LTR_V:   pattern_o = 16'hAB80;
            LTR_W:   pattern_o = 16'hBB80;
            LTR_X:   pattern_o = 16'hEAE0;
            LTR_Y:   pattern_o = 16'hEBB8;
            LTR_Z:   pattern_o = 16'hEEA0;
            default: pattern_o = '0;
        endcase
    end

    // R1
    always_comb begin
        pad_bit_chk: assert (pattern_o[0] == 1'b0);
    end

endmodule

// File: rtl/morse_shift_player.sv
module morse_shift_player
    import morse_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     load_i,
    input  pattern_t pattern_i,
    input  logic     tick_i,
    output logic     busy_o,
    output logic     bit_o
);

    localparam int unsigned SW = $clog2(PAT_W);
    localparam logic [SW-1:0] LAST_SLOT = SW'(PAT_W - 1);

    typedef struct packed {
        logic          busy;
        pattern_t      shreg;
        logic [SW-1:0] slot;
    } player_t;

    player_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load_i) begin
                st_d.busy  = 1'b1;
                st_d.shreg = pattern_i;
                st_d.slot  = '0;
            end
        end else if (tick_i) begin
            st_d.shreg = {st_q.shreg[PAT_W-2:0], 1'b0};
            st_d.slot  = st_q.slot + 1'b1;
            if (st_q.slot == LAST_SLOT) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign bit_o  = st_q.shreg[PAT_W-1];

    // R3
    shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && tick_i && st_q.slot != LAST_SLOT)
        |=> (st_q.shreg == {$past(st_q.shreg[PAT_W-2:0]), 1'b0}));

    // R4
    end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && tick_i && st_q.slot == LAST_SLOT) |=> !st_q.busy);

    // R6
    hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.busy && !tick_i) |=> ($stable(st_q.shreg) && $stable(st_q.slot) && st_q.busy));

endmodule

// File: rtl/morse_letter_tx.sv
module morse_letter_tx
    import morse_pkg::*;
#(
    parameter int unsigned CLK_HZ        = 50_000_000,
    parameter int unsigned SLOTS_PER_SEC = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic [2:0] letter_i,
    output logic       led_o
);

    localparam int unsigned CYCLES_PER_SLOT = CLK_HZ / SLOTS_PER_SEC;

    logic     start_d, start_q;
    logic     rise_w, load_w, busy_w, bit_w, tick_w;
    pattern_t pattern_w;

    // Remember the previous start level to find its rising edge
    always_comb begin
        start_d = start_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            start_q <= 1'b0;
        end else begin
            start_q <= start_d;
        end
    end

    assign rise_w = start_i && !start_q;
    assign load_w = rise_w && !busy_w;

    morse_pattern_rom i_rom (
        .letter_i  (letter_i),
        .pattern_o (pattern_w)
    );

    morse_slot_timer #(
        .CYCLES_PER_SLOT (CYCLES_PER_SLOT)
    ) i_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (busy_w),
        .restart_i (load_w),
        .tick_o    (tick_w)
    );

    morse_shift_player i_player (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load_w),
        .pattern_i (pattern_w),
        .tick_i    (tick_w),
        .busy_o    (busy_w),
        .bit_o     (bit_w)
    );

    assign led_o = busy_w && bit_w;

    // R5
    start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_w) |-> ($past(start_i) && !$past(start_q)));

    // R4
    idle_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_w |-> !led_o);

endmodule

// File: tb/test_morse_letter_tx.sv
module test_morse_letter_tx;

    localparam int CLK_HZ = 8;
    localparam int SPS    = 2;
    localparam int N      = CLK_HZ / SPS;
    localparam int SLOTS  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] letter = 3'd0;
    logic       led;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    morse_letter_tx #(.CLK_HZ(CLK_HZ), .SLOTS_PER_SEC(SPS)) i_morse_letter_tx (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .letter_i (letter),
        .led_o    (led)
    );

    function automatic string code_of(input logic [2:0] l);
        case (l)
            3'd0: return "...";
            3'd1: return "-";
            3'd2: return "..-";
            3'd3: return "...-";
            3'd4: return ".--";
            3'd5: return "-..-";
            3'd6: return "-.--";
            default: return "--..";
        endcase
    endfunction

    // Build the slot pattern from dots and dashes
    function automatic logic [15:0] expect_pat(input logic [2:0] l);
        string s = code_of(l);
        logic [15:0] p = '0;
        int pos = 15;
        for (int k = 0; k < s.len(); k++) begin
            if (s[k] == "-") begin
                p[pos] = 1'b1; p[pos-1] = 1'b1; p[pos-2] = 1'b1;
                pos -= 4;
            end else begin
                p[pos] = 1'b1;
                pos -= 2;
            end
        end
        return p;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0 clean, 1 start held high, 2 second start mid-run, 3 letter changed mid-run
    task automatic play(input logic [2:0] ltr, input int mode, input string req);
        logic [15:0] exp = expect_pat(ltr);
        int bad = 0;
        int first_bad = -1;
        int idle_bad = 0;
        @(negedge clk);
        letter = ltr;
        start  = 1'b1;
        for (int i = 0; i < SLOTS * N; i++) begin
            @(negedge clk);
            if (led !== exp[15 - i / N]) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
            if (i == 0 && mode != 1) start = 1'b0;
            if (mode == 2 && i == 20) begin start = 1'b1; letter = ~ltr; end
            if (mode == 2 && i == 21) start = 1'b0;
            if (mode == 3 && i == 5) letter = ltr + 3'd3;
        end
        check(bad == 0, req, first_bad, -1);
        for (int i = 0; i < 3 * N; i++) begin
            @(negedge clk);
            if (led !== 1'b0) idle_bad++;
        end
        check(idle_bad == 0, (mode == 1) ? "R5" : "R4", idle_bad, 0);
        start = 1'b0;
    endtask

    task automatic reset_mid;
        int idle_bad = 0;
        @(negedge clk);
        letter = 3'd6;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(led === 1'b1, "R8", led, 1);
        #1 rst_n = 1'b0;
        #1 check(led === 1'b0, "R8", led, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 5 * N; i++) begin
            @(negedge clk);
            if (led !== 1'b0) idle_bad++;
        end
        check(idle_bad == 0, "R8", idle_bad, 0);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(led === 1'b0, "R9", led, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(led === 1'b0, "R9", led, 0);

        for (int l = 0; l < 8; l++) begin
            play(3'(l), 0, (l == 1) ? "R2" : ((l == 5) ? "R3" : "R1"));
        end
        play(3'd4, 1, "R5");
        play(3'd7, 2, "R6");
        play(3'd0, 3, "R7");
        reset_mid();
        play(3'd5, 0, "R10");
        play(3'd5, 0, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule